// File: doc/BRIEF.md
# Burst Memory Matrix-Vector Engine

This engine moves data between an external word-addressed memory and an on-chip datapath by way of a simple request/acknowledge burst interface. Reads and writes use two independent channels. Each channel has a request with address and beat count, which stays raised until the memory side acknowledges it, and a per-beat data path. One run is launched by a rising edge on a trigger input. Mode, matrix dimension, burst length and the two base addresses are sampled at that edge.

In matrix mode the engine reads a contiguous region that holds the N-element input vector followed by the N×N matrix in row-major order. The vector goes into an internal buffer. Each matrix row is then streamed through a signed fixed-point multiply-accumulate stage. The N results are buffered and written back as consecutive words from the write base. In loopback mode the engine reads one burst of the configured length into the buffer and writes the same words back unchanged, which gives a quick check of the memory path. A one-cycle done pulse marks completion. A one-cycle error pulse marks a rejected configuration.

Top module: `mvm_burst_engine`

## Requirements
- R1: With `mode_mat`=1 and size N, the region at `rd_start_addr` holds x[0..N-1] followed by A[i][j] at offset N+i·N+j. Output word i, written to `wr_base_addr`+i, equals (Σj A[i][j]·x[j]) arithmetically shifted right by FRAC_W and truncated to DATA_W bits, using two's-complement operands.
- R2: With `mode_mat`=0, exactly `burst_len` words are read from `rd_start_addr`. The same words are then written in the same order from `wr_base_addr`.
- R3: Only a rising edge of `trig` starts a run. Edges that arrive while a run is active are ignored, including an edge in the same cycle as the final write beat.
- R4: A matrix size outside 2..DIM_MAX (4000 by default) in matrix mode, or a `burst_len` of 0 in either mode, produces a one-cycle `err` pulse in the cycle after the edge. No request and no `done` follow.
- R5: A raised read request keeps `rd_addr` and `rd_len` steady until `rd_ack` is seen high.
- R6: Read bursts carry min(`burst_len`, words still to read) beats. Each burst starts at the read start plus the number of words already requested, so addresses advance by one per beat.
- R7: Write bursts follow the same sizing rule from the write base, and hold their request until `wr_ack`. A beat is accepted when `wr_dvalid` and `wr_ready` are both high. `done` is high for exactly the one cycle after the final beat is accepted.
- R8: The accumulator restarts at every row, so each output depends only on its own row. This holds even when a burst straddles rows.
- R9: During and just after reset, `rd_req`, `wr_req`, `wr_dvalid`, `done` and `err` are low.
- R10: Mode, size, burst length and write base are captured at the starting edge. Changing them mid-run does not alter that run's traffic or results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_mat | input | 1 | 1 = matrix-vector product, 0 = loopback |
| mat_size | input | DIM_W | Matrix dimension N |
| burst_len | input | LEN_W | Maximum beats per burst |
| rd_start_addr | input | ADDR_W | Word address of the first word read |
| wr_base_addr | input | ADDR_W | Word address of the first result written |
| trig | input | 1 | Start trigger, rising-edge sensitive |
| rd_req | output | 1 | Read burst request |
| rd_addr | output | ADDR_W | Read burst start address |
| rd_len | output | LEN_W | Read burst beat count |
| rd_ack | input | 1 | Memory accepts the read request |
| rd_data | input | DATA_W | Read beat data |
| rd_dvalid | input | 1 | Read beat valid |
| wr_req | output | 1 | Write burst request |
| wr_addr | output | ADDR_W | Write burst start address |
| wr_len | output | LEN_W | Write burst beat count |
| wr_ack | input | 1 | Memory accepts the write request |
| wr_data | output | DATA_W | Write beat data |
| wr_dvalid | output | 1 | Write beat valid |
| wr_ready | input | 1 | Memory takes the write beat |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle configuration error pulse |

## Verification
Two things can land in the same clock edge: the acceptance of the final write beat, which ends a run, and a fresh trigger edge. The bench provokes this by having its memory model raise `trig` at the moment it presents the last expected write beat. It then requires exactly one `done` and no new read request while the trigger stays high. A second coincidence comes from bursts that straddle row boundaries. There, the last beat of one row and the first beat of the next arrive back to back, so a row's closing result and the accumulator restart share a cycle. Matrix runs whose burst length does not divide N compare every result word against an independently computed product.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_READ  = 2'd1,
    ENG_WRITE = 2'd2
  } eng_state_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;
endpackage

// File: rtl/mvm_trig_edge.sv
module mvm_trig_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic rise
);
  logic trig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig;
  end

  assign rise = trig & ~trig_q;
endmodule

// File: rtl/mvm_burst_seq.sv
module mvm_burst_seq
  import mvm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  total,
  input  logic [LEN_W-1:0]  blen,
  output logic              req,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o,
  input  logic              ack,
  input  logic              beat,
  output logic              in_data,
  output logic              last
);
  seq_state_e        st, st_n;
  logic [ADDR_W-1:0] cur_addr, addr_n;
  logic [CNT_W-1:0]  remain, remain_n;
  logic [LEN_W-1:0]  beats_left, beats_n;
  logic [LEN_W-1:0]  len_c;

  assign len_c   = (remain < CNT_W'(blen)) ? LEN_W'(remain) : blen;
  assign req     = (st == SEQ_REQ);
  assign addr_o  = cur_addr;
  assign len_o   = len_c;
  assign in_data = (st == SEQ_DATA);
  assign last    = in_data && beat && (remain == CNT_W'(1));

  always_comb begin
    st_n     = st;
    addr_n   = cur_addr;
    remain_n = remain;
    beats_n  = beats_left;
    case (st)
      SEQ_IDLE: if (start) begin
        st_n     = SEQ_REQ;
        addr_n   = base;
        remain_n = total;
      end
      SEQ_REQ: if (ack) begin
        st_n    = SEQ_DATA;
        beats_n = len_c;
      end
      SEQ_DATA: if (beat) begin
        addr_n   = cur_addr + ADDR_W'(1);
        remain_n = remain - CNT_W'(1);
        beats_n  = beats_left - LEN_W'(1);
        if (remain == CNT_W'(1))          st_n = SEQ_IDLE;
        else if (beats_left == LEN_W'(1)) st_n = SEQ_REQ;
      end
      default: st_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SEQ_IDLE;
      cur_addr   <= '0;
      remain     <= '0;
      beats_left <= '0;
    end else begin
      st         <= st_n;
      cur_addr   <= addr_n;
      remain     <= remain_n;
      beats_left <= beats_n;
    end
  end
endmodule

// File: rtl/mvm_mac.sv
module mvm_mac #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 48,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              clr,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] res
);
  logic signed [ACC_W-1:0]    acc, acc_nx;
  logic signed [2*DATA_W-1:0] prod;

  assign prod   = $signed(a) * $signed(x);
  assign acc_nx = (clr ? ACC_W'(0) : acc) + ACC_W'(prod);
  assign res    = acc_nx[FRAC_W +: DATA_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= acc_nx;
  end
endmodule

// File: rtl/mvm_burst_engine.sv
module mvm_burst_engine
  import mvm_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 8,
  parameter int DIM_MAX = 4000,
  parameter int FRAC_W  = 8,
  parameter int ACC_W   = 48,
  localparam int DIM_W  = $clog2(DIM_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_mat,
  input  logic [DIM_W-1:0]  mat_size,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic [ADDR_W-1:0] rd_start_addr,
  input  logic [ADDR_W-1:0] wr_base_addr,
  input  logic              trig,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [LEN_W-1:0]  rd_len,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_dvalid,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_len,
  input  logic              wr_ack,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_dvalid,
  input  logic              wr_ready,
  output logic              done,
  output logic              err
);
  localparam int CNT_W = 2 * DIM_W + 1;

  logic rst_s1, rst_s2, core_rst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  assign core_rst_n = rst_s2;

  eng_state_e        st, st_n;
  logic              mode_q;
  logic [DIM_W-1:0]  size_q;
  logic [LEN_W-1:0]  blen_q;
  logic [ADDR_W-1:0] wbase_q;
  logic [CNT_W-1:0]  idx;
  logic [DIM_W-1:0]  col, row, widx;
  logic              err_q, done_q;

  logic [DATA_W-1:0] vec_mem [DIM_MAX];
  logic [DATA_W-1:0] res_mem [DIM_MAX];

  logic             trig_rise, size_ok, cfg_bad, go, rd_go;
  logic [CNT_W-1:0] rd_total, wr_total;
  logic             rd_in_data, rd_last, rd_beat;
  logic             wr_in_data, wr_last, wr_beat;
  logic             mac_en, row_end, vec_we, res_we;
  logic [DATA_W-1:0] mac_res;

  mvm_trig_edge u_edge (
    .clk (clk), .rst_n (core_rst_n), .trig (trig), .rise (trig_rise)
  );

  assign size_ok  = (mat_size >= DIM_W'(2)) && (mat_size <= DIM_W'(DIM_MAX));
  assign cfg_bad  = (mode_mat && !size_ok) || (burst_len == '0);
  assign go       = trig_rise && (st == ENG_IDLE);
  assign rd_go    = go && !cfg_bad;
  assign rd_total = mode_mat ? (CNT_W'(mat_size) * CNT_W'(mat_size) + CNT_W'(mat_size))
                             : CNT_W'(burst_len);
  assign wr_total = mode_q ? CNT_W'(size_q) : CNT_W'(blen_q);

  mvm_burst_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_rd_seq (
    .clk (clk), .rst_n (core_rst_n), .start (rd_go), .base (rd_start_addr),
    .total (rd_total), .blen (blen_q), .req (rd_req), .addr_o (rd_addr),
    .len_o (rd_len), .ack (rd_ack), .beat (rd_beat), .in_data (rd_in_data),
    .last (rd_last)
  );

  mvm_burst_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_wr_seq (
    .clk (clk), .rst_n (core_rst_n), .start (rd_last), .base (wbase_q),
    .total (wr_total), .blen (blen_q), .req (wr_req), .addr_o (wr_addr),
    .len_o (wr_len), .ack (wr_ack), .beat (wr_beat), .in_data (wr_in_data),
    .last (wr_last)
  );

  assign rd_beat = rd_in_data && rd_dvalid;
  assign mac_en  = rd_beat && mode_q && (idx >= CNT_W'(size_q));
  assign row_end = (col == size_q - DIM_W'(1));
  assign vec_we  = rd_beat && !mac_en;
  assign res_we  = mac_en && row_end;

  mvm_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_mac (
    .clk (clk), .rst_n (core_rst_n), .en (mac_en), .clr (col == '0),
    .a (rd_data), .x (vec_mem[col]), .res (mac_res)
  );

  assign wr_dvalid = wr_in_data;
  assign wr_beat   = wr_in_data && wr_ready;
  assign wr_data   = mode_q ? res_mem[widx] : vec_mem[widx];
  assign done      = done_q;
  assign err       = err_q;

  always_comb begin
    st_n = st;
    case (st)
      ENG_IDLE:  if (rd_go)   st_n = ENG_READ;
      ENG_READ:  if (rd_last) st_n = ENG_WRITE;
      ENG_WRITE: if (wr_last) st_n = ENG_IDLE;
      default:                st_n = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      st      <= ENG_IDLE;
      mode_q  <= 1'b0;
      size_q  <= '0;
      blen_q  <= '0;
      wbase_q <= '0;
      idx     <= '0;
      col     <= '0;
      row     <= '0;
      widx    <= '0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st     <= st_n;
      err_q  <= go && cfg_bad;
      done_q <= wr_last;
      if (go) begin
        mode_q  <= mode_mat;
        size_q  <= mat_size;
        blen_q  <= burst_len;
        wbase_q <= wr_base_addr;
      end
      if (rd_go) begin
        idx <= '0;
        col <= '0;
        row <= '0;
      end else if (rd_beat) begin
        idx <= idx + CNT_W'(1);
        if (mac_en) begin
          if (row_end) begin
            col <= '0;
            row <= row + DIM_W'(1);
          end else begin
            col <= col + DIM_W'(1);
          end
        end
      end
      if (rd_last)      widx <= '0;
      else if (wr_beat) widx <= widx + DIM_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (vec_we) vec_mem[idx[DIM_W-1:0]] <= rd_data;
    if (res_we) res_mem[row] <= mac_res;
  end
endmodule

// File: rtl/mvm_burst_engine_chk.sv
module mvm_burst_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [LEN_W-1:0]  rd_len,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [LEN_W-1:0]  wr_len,
  input logic              done,
  input logic              err
);
  // R5
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr) && $stable(rd_len)));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_len)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rd_req && !wr_req && !done));

  // R6
  rd_len_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_len != '0));

  // R3
  chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));
endmodule

bind mvm_burst_engine mvm_burst_engine_chk #(
  .ADDR_W (ADDR_W),
  .LEN_W  (LEN_W)
) u_chk (.*);

// File: tb/mvm_burst_engine_tb.sv
module mvm_burst_engine_tb;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 8;
  localparam int DIM_MAX = 4000;
  localparam int FRAC_W  = 8;
  localparam int DIM_W   = $clog2(DIM_MAX + 1);

  typedef struct { longint a; longint l; } req_t;
  typedef struct { longint a; longint d; string tag; } beat_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_mat = 1'b0;
  logic [DIM_W-1:0]  mat_size = '0;
  logic [LEN_W-1:0]  burst_len = '0;
  logic [ADDR_W-1:0] rd_start_addr = '0;
  logic [ADDR_W-1:0] wr_base_addr = '0;
  logic trig = 1'b0;
  logic rd_req, wr_req, wr_dvalid, done, err;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [LEN_W-1:0]  rd_len, wr_len;
  logic [DATA_W-1:0] wr_data;
  logic rd_ack = 1'b0, rd_dvalid = 1'b0, wr_ack = 1'b0, wr_ready = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;

  always #4 clk = ~clk;

  mvm_burst_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
                     .DIM_MAX(DIM_MAX), .FRAC_W(FRAC_W)) u_dut (
    .clk, .rst_n, .mode_mat, .mat_size, .burst_len, .rd_start_addr,
    .wr_base_addr, .trig, .rd_req, .rd_addr, .rd_len, .rd_ack, .rd_data,
    .rd_dvalid, .wr_req, .wr_addr, .wr_len, .wr_ack, .wr_data, .wr_dvalid,
    .wr_ready, .done, .err
  );

  int     nchk = 0, nerr = 0, cyc = 0, done_cnt = 0, err_cnt = 0, req_cnt = 0;
  bit     done_exp = 0, retrig_arm = 0, finished = 0;
  longint mem [longint];
  req_t   rdq[$], wrq[$];
  beat_t  wbq[$];
  longint rpend = 0, ra = 0, rla = 0, rl = 0, wpend = 0, wa = 0, wla = 0, wl = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic push_reqs(ref req_t q[$], input longint base, input longint total,
                           input longint bl);
    longint rem = total, a = base;
    while (rem > 0) begin
      longint l = (rem < bl) ? rem : bl;
      q.push_back('{a, l});
      a += l;
      rem -= l;
    end
  endtask

  // memory model and monitor
  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (err) err_cnt++;
    if (done_exp) begin
      chk(done === 1'b1, "R7", "done in cycle after last beat", longint'(done), 1);
      done_exp = 0;
    end
    // read channel
    if (rd_dvalid) begin rpend--; ra++; end
    if (rd_ack) begin
      rd_ack = 1'b0; rpend = rl; ra = rla;
    end else if (rd_req && rpend == 0 && (cyc % 3) != 0) begin
      req_t e;
      req_cnt++;
      if (rdq.size() == 0) chk(0, "R3 R4", "unexpected read request", longint'(rd_addr), -1);
      else begin
        e = rdq.pop_front();
        chk(rd_addr == ADDR_W'(e.a), "R6", "read burst address", longint'(rd_addr), e.a);
        chk(rd_len == LEN_W'(e.l), "R6", "read burst length", longint'(rd_len), e.l);
      end
      rla = longint'(rd_addr); rl = longint'(rd_len); rd_ack = 1'b1;
    end
    rd_dvalid = (rpend > 0) && ((cyc % 4) != 1);
    rd_data   = mem.exists(ra) ? DATA_W'(mem[ra]) : '0;
    // write channel
    if (wr_ack) begin
      wr_ack = 1'b0; wpend = wl; wa = wla;
    end else if (wr_req && wpend == 0) begin
      req_t e;
      if (wrq.size() == 0) chk(0, "R3", "unexpected write request", longint'(wr_addr), -1);
      else begin
        e = wrq.pop_front();
        chk(wr_addr == ADDR_W'(e.a), "R7", "write burst address", longint'(wr_addr), e.a);
        chk(wr_len == LEN_W'(e.l), "R7", "write burst length", longint'(wr_len), e.l);
      end
      wla = longint'(wr_addr); wl = longint'(wr_len); wr_ack = 1'b1;
    end
    wr_ready = (cyc % 3) != 2;
    if (wr_dvalid && wr_ready && wpend > 0) begin
      beat_t b;
      if (wbq.size() == 0) chk(0, "R3", "unexpected write beat", longint'(wr_data), -1);
      else begin
        b = wbq.pop_front();
        chk(longint'(wa) == b.a, b.tag, "write beat address", wa, b.a);
        chk(wr_data == DATA_W'(b.d), b.tag, "write beat data", longint'(wr_data),
            longint'(DATA_W'(b.d)));
        if (wbq.size() == 0) begin
          done_exp = 1;
          if (retrig_arm) trig = 1'b1;
        end
      end
      wa++; wpend--;
    end
  end

  task automatic run_op(input bit m, input int n, input int bl, input longint rb,
                        input longint wb, input bit busy, input string tag);
    int d0 = done_cnt;
    int t = 0;
    longint rtot, wtot;
    if (m) begin
      for (int k = 0; k < n + n * n; k++) mem[rb + k] = ((k * 37 + 5) % 41 - 20) * 48;
      for (int i = 0; i < n; i++) begin
        longint s = 0;
        for (int j = 0; j < n; j++) s += mem[rb + n + i * n + j] * mem[rb + j];
        wbq.push_back('{wb + i, s >>> FRAC_W, tag});
      end
      rtot = n + n * n; wtot = n;
    end else begin
      for (int k = 0; k < bl; k++) begin
        mem[rb + k] = (k * 4099 + 17) % 65536 - 32768;
        wbq.push_back('{wb + k, mem[rb + k], tag});
      end
      rtot = bl; wtot = bl;
    end
    push_reqs(rdq, rb, rtot, bl);
    push_reqs(wrq, wb, wtot, bl);
    @(negedge clk);
    mode_mat = m; mat_size = DIM_W'(n); burst_len = LEN_W'(bl);
    rd_start_addr = ADDR_W'(rb); wr_base_addr = ADDR_W'(wb); trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    if (busy) begin
      repeat (4) @(negedge clk);
      mode_mat = ~m; mat_size = DIM_W'(2); burst_len = LEN_W'(1);
      wr_base_addr = ADDR_W'(32'h0000_7000); trig = 1'b1;
      @(negedge clk) trig = 1'b0;
      repeat (3) @(negedge clk);
      trig = 1'b1;
      @(negedge clk) trig = 1'b0;
      retrig_arm = 1;
    end
    while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
    repeat (25) @(negedge clk);
    chk(done_cnt == d0 + 1, busy ? "R3" : "R7", "done pulses per run", done_cnt - d0, 1);
    chk(wbq.size() == 0, tag, "write beats outstanding", wbq.size(), 0);
    chk(rdq.size() == 0, "R6", "read bursts outstanding", rdq.size(), 0);
    chk(wrq.size() == 0, "R7", "write bursts outstanding", wrq.size(), 0);
    retrig_arm = 0;
    trig = 1'b0;
    wbq.delete(); rdq.delete(); wrq.delete();
  endtask

  task automatic err_case(input bit m, input int n, input int bl, input string what);
    int e0 = err_cnt, d0 = done_cnt, r0 = req_cnt;
    @(negedge clk);
    mode_mat = m; mat_size = DIM_W'(n); burst_len = LEN_W'(bl); trig = 1'b1;
    @(negedge clk) trig = 1'b0;
    chk(err === 1'b1, "R4", {what, " err timing"}, longint'(err), 1);
    repeat (20) @(negedge clk);
    chk(err_cnt == e0 + 1, "R4", {what, " err pulses"}, err_cnt - e0, 1);
    chk(req_cnt == r0 && done_cnt == d0, "R4", {what, " no traffic"}, req_cnt - r0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk({rd_req, wr_req, wr_dvalid, done, err} == 5'b0, "R9", "outputs in reset",
        longint'({rd_req, wr_req, wr_dvalid, done, err}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk({rd_req, wr_req, wr_dvalid, done, err} == 5'b0, "R9", "outputs after reset",
        longint'({rd_req, wr_req, wr_dvalid, done, err}), 0);
    run_op(0, 0, 5, 64'h40, 64'h1000_0000, 0, "R2");
    run_op(1, 3, 4, 64'h0, 64'h1000_0000, 0, "R1 R8");
    run_op(1, 2, 1, 64'h200, 64'h1000_0100, 0, "R1");
    run_op(1, 5, 7, 64'h300, 64'h1000_0200, 0, "R8");
    err_case(1, 1, 4, "size 1");
    err_case(1, 4001, 4, "size 4001");
    err_case(0, 3, 0, "burst 0");
    run_op(0, 0, 6, 64'h500, 64'h1000_0400, 1, "R10");
    run_op(1, 4, 3, 64'h600, 64'h1000_0500, 0, "R1");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule